// File: doc/BRIEF.md
# Bus Master Privilege Gate

This block sits on a simple single-cycle register bus that several bus masters share. It holds a privilege register with one bit for each of four masters, and it uses that register for two things. The first is to work out the effective supervisor/user attribute of every access. A master whose bit is clear is always treated as user mode. A master whose bit is set has its own attribute passed through unchanged. The second is to decide which masters are trusted, and so may change the block's own control registers.

Beside the privilege register, the block holds a small bank of 32-bit access-level words. They are plain read/write storage that a downstream permission checker can use. Every write to a mapped control register is checked against the sender's privilege bit, using the value the register held before the write. A write from an untrusted master ends with a one-cycle error response and changes nothing. Master 0 is the processor, and its bit is hardwired to one, so it can never lock itself out.

Top module: `master_priv_gate`

## Requirements
- R1: After reset, the privilege register at byte offset 0x020 reads 0x0000_0003, which marks masters 0 and 1 trusted. Each access-level word reads 0.
- R2: Bit 0 of the privilege register always reads 1. A write of 0 to that bit has no effect.
- R3: `effSuper` is combinational. It equals `busSuper` when the privilege bit of master `busMaster` is 1, and it is 0 when that bit is 0.
- R4: A write (`busSel`=1, `busWrite`=1) to a mapped register from a trusted master updates that register at the next clock edge and does not raise `busErr`.
- R5: A write to a mapped register from a master whose privilege bit is 0 raises `busErr` in that same cycle, and no register changes.
- R6: A read (`busSel`=1, `busWrite`=0) from any master never raises `busErr`. `rdData` shows the addressed register in the same cycle.
- R7: Bits 31 to 4 of the privilege register read as 0, and the values written to them are ignored.
- R8: The trust check uses the privilege value from before the current write. A trusted master may clear its own bit. After that, its next write is rejected.
- R9: The three access-level words sit at byte offsets 0x024, 0x028 and 0x02C. Each holds a full 32-bit value on its own, with no effect on the others.
- R10: An address outside 0x020 to 0x02C reads as 0. A write to such an address changes nothing and does not raise `busErr`.
- R11: `busErr` is 1 only in a cycle with `busSel`=1 and `busWrite`=1. When `busSel`=0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address inside the register window |
| busWdata | input | 32 | Write data |
| busMaster | input | 2 | ID of the master making the access |
| busSuper | input | 1 | Supervisor attribute driven by the master |
| rdData | output | 32 | Read data for the addressed register |
| busErr | output | 1 | Error termination for a rejected write |
| effSuper | output | 1 | Effective supervisor attribute of the access |

## Verification
The bench has a trusted master clear its own privilege bit. If the design checked trust after the update, that write would be rejected. If it kept a stale trust copy, the master's next write would still be accepted. The bench also tries to clear bit 0 and to set reserved bits. A design that stored those bits would read back a 0 in bit 0 or nonzero upper bits. Rejected writes are followed by readback, which catches a design that flags the error but still stores the data. Writes to unmapped addresses and writes with `busSel` low are checked too, which catches a design that raises spurious errors or decodes the address too loosely.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

  localparam int IDX_W = 4;

  typedef struct packed {
    logic             privWe;
    logic             aclWe;
    logic             rdPriv;
    logic             rdAcl;
    logic [IDX_W-1:0] aclIdx;
  } mpgStrobe_t;

endpackage

// File: rtl/mpg_ctrl.sv
module mpg_ctrl
  import mpg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_ACL     = 3,
  parameter int PRIV_OFFS   = 32'h20,
  localparam int ID_W       = $clog2(NUM_MASTERS),
  localparam int WORD_W     = ADDR_W - 2
) (
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [ID_W-1:0]        busMaster,
  input  logic                   busSuper,
  input  logic [NUM_MASTERS-1:0] privVal,
  output mpgStrobe_t             strobe,
  output logic                   busErr,
  output logic                   effSuper
);

  localparam logic [WORD_W-1:0] PRIV_WORD = WORD_W'(PRIV_OFFS >> 2);
  localparam logic [WORD_W-1:0] ACL_FIRST = PRIV_WORD + WORD_W'(1);
  localparam logic [WORD_W-1:0] ACL_LAST  = PRIV_WORD + WORD_W'(NUM_ACL);

  logic [WORD_W-1:0] wordIdx;
  logic [WORD_W-1:0] aclOff;
  logic              hitPriv;
  logic              hitAcl;
  logic              trusted;
  logic              wrReq;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign hitPriv = (wordIdx == PRIV_WORD);
  assign hitAcl  = (wordIdx >= ACL_FIRST) && (wordIdx <= ACL_LAST);
  assign aclOff  = wordIdx - ACL_FIRST;

  // trust comes from the register value before this cycle's write lands
  assign trusted = privVal[busMaster];
  assign wrReq   = busSel && busWrite && (hitPriv || hitAcl);

  always_comb begin
    strobe        = '0;
    strobe.privWe = wrReq && trusted && hitPriv;
    strobe.aclWe  = wrReq && trusted && hitAcl;
    strobe.rdPriv = busSel && hitPriv;
    strobe.rdAcl  = busSel && hitAcl;
    strobe.aclIdx = IDX_W'(aclOff);
  end

  assign busErr   = wrReq && !trusted;
  assign effSuper = privVal[busMaster] && busSuper;

endmodule

// File: rtl/mpg_regs.sv
module mpg_regs
  import mpg_pkg::*;
#(
  parameter int                     DATA_W      = 32,
  parameter int                     NUM_MASTERS = 4,
  parameter int                     NUM_ACL     = 3,
  parameter logic [NUM_MASTERS-1:0] PRIV_RESET  = NUM_MASTERS'(3)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mpgStrobe_t             strobe,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [NUM_MASTERS-1:0] privVal,
  output logic [DATA_W-1:0]      rdData
);

  logic [NUM_MASTERS-1:1] privUpper;
  logic [DATA_W-1:0]      aclReg [NUM_ACL];
  logic [DATA_W-1:0]      aclRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      privUpper <= PRIV_RESET[NUM_MASTERS-1:1];
    end else if (strobe.privWe) begin
      privUpper <= busWdata[NUM_MASTERS-1:1];
    end
  end

  // master 0 stays trusted no matter what is written
  assign privVal = {privUpper, 1'b1};

  for (genvar g = 0; g < NUM_ACL; g++) begin : gAcl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aclReg[g] <= '0;
      end else if (strobe.aclWe && (strobe.aclIdx == IDX_W'(g))) begin
        aclReg[g] <= busWdata;
      end
    end
  end

  always_comb begin
    aclRd = '0;
    for (int i = 0; i < NUM_ACL; i++) begin
      if (strobe.aclIdx == IDX_W'(i)) aclRd = aclReg[i];
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdPriv)     rdData = DATA_W'(privVal);
    else if (strobe.rdAcl) rdData = aclRd;
  end

endmodule

// File: rtl/master_priv_gate.sv
module master_priv_gate
  import mpg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_ACL     = 3,
  parameter int PRIV_OFFS   = 32'h20,
  localparam int ID_W       = $clog2(NUM_MASTERS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ID_W-1:0]   busMaster,
  input  logic              busSuper,
  output logic [DATA_W-1:0] rdData,
  output logic              busErr,
  output logic              effSuper
);

  mpgStrobe_t             strobe;
  logic [NUM_MASTERS-1:0] privVal;

  mpg_ctrl #(
    .ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS),
    .NUM_ACL(NUM_ACL), .PRIV_OFFS(PRIV_OFFS)
  ) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busMaster(busMaster), .busSuper(busSuper), .privVal(privVal),
    .strobe(strobe), .busErr(busErr), .effSuper(effSuper)
  );

  mpg_regs #(
    .DATA_W(DATA_W), .NUM_MASTERS(NUM_MASTERS), .NUM_ACL(NUM_ACL)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .privVal(privVal), .rdData(rdData)
  );

  localparam logic [ADDR_W-3:0] PRIV_WORD = (ADDR_W-2)'(PRIV_OFFS >> 2);

  // R5: a rejected write leaves the privilege register untouched
  a_r5_err_keeps_priv: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> $stable(privVal));

  // R11: an error only terminates a write access
  a_r11_err_only_write: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busSel && busWrite));

  // R6: reads never abort
  a_r6_read_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |-> !busErr);

  // R3: an unprivileged master is seen as user mode
  a_r3_user_forced: assert property (@(posedge clk) disable iff (!rstN)
    !privVal[busMaster] |-> !effSuper);

  // R2: bit 0 of the privilege readback is always one
  a_r2_bit0_reads_one: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr[ADDR_W-1:2] == PRIV_WORD) |-> rdData[0]);

  // R7: reserved privilege bits read as zero
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr[ADDR_W-1:2] == PRIV_WORD) |-> (rdData[DATA_W-1:NUM_MASTERS] == '0));

endmodule

// File: tb/master_priv_gate_test.sv
module master_priv_gate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [1:0]  busMaster = '0;
  logic        busSuper = 1'b0;
  logic [31:0] rdData;
  logic        busErr;
  logic        effSuper;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  master_priv_gate uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busMaster(busMaster),
    .busSuper(busSuper), .rdData(rdData), .busErr(busErr), .effSuper(effSuper)
  );

  // {wr, master, super, addr, wdata, expErr, expRd, expEff}
  localparam int NV = 17;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 2'd2, 1'b1, 8'h20, 32'h0,         1'b0, 32'h0000_0003, 1'b0}, // R1 R3 R6
    {1'b0, 2'd3, 1'b0, 8'h24, 32'h0,         1'b0, 32'h0,         1'b0}, // R1
    {1'b1, 2'd0, 1'b1, 8'h24, 32'hA5A5_0001, 1'b0, 32'h0,         1'b1}, // R4
    {1'b0, 2'd3, 1'b1, 8'h24, 32'h0,         1'b0, 32'hA5A5_0001, 1'b0}, // R9
    {1'b1, 2'd2, 1'b0, 8'h28, 32'h0000_1234, 1'b1, 32'h0,         1'b0}, // R5
    {1'b0, 2'd0, 1'b0, 8'h28, 32'h0,         1'b0, 32'h0,         1'b0}, // R5
    {1'b1, 2'd1, 1'b1, 8'h20, 32'hFFFF_FFF4, 1'b0, 32'h0,         1'b1}, // R8
    {1'b0, 2'd1, 1'b1, 8'h20, 32'h0,         1'b0, 32'h0000_0005, 1'b0}, // R2 R7
    {1'b1, 2'd1, 1'b0, 8'h2C, 32'h0000_0077, 1'b1, 32'h0,         1'b0}, // R8
    {1'b0, 2'd2, 1'b1, 8'h2C, 32'h0,         1'b0, 32'h0,         1'b1}, // R3
    {1'b1, 2'd2, 1'b0, 8'h2C, 32'h0000_CAFE, 1'b0, 32'h0,         1'b0}, // R4
    {1'b0, 2'd0, 1'b1, 8'h2C, 32'h0,         1'b0, 32'h0000_CAFE, 1'b1}, // R9
    {1'b1, 2'd3, 1'b1, 8'h40, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0}, // R10
    {1'b0, 2'd0, 1'b0, 8'h40, 32'h0,         1'b0, 32'h0,         1'b0}, // R10
    {1'b1, 2'd0, 1'b1, 8'h20, 32'h0,         1'b0, 32'h0,         1'b1}, // R2
    {1'b0, 2'd0, 1'b1, 8'h20, 32'h0,         1'b0, 32'h0000_0001, 1'b1}, // R2
    {1'b0, 2'd1, 1'b0, 8'h24, 32'h0,         1'b0, 32'hA5A5_0001, 1'b0}  // R9
  };

  function automatic string tagOf(int idx);
    case (idx)
      0, 1:     return "R1";
      2, 10:    return "R4";
      4, 5:     return "R5";
      6, 8:     return "R8";
      7:        return "R7";
      9:        return "R3";
      12, 13:   return "R10";
      14, 15:   return "R2";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive after a falling edge, sample 1 ns later, the write lands on the next rising edge
  task automatic access(logic wr, logic [1:0] m, logic s, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busMaster = m; busSuper = s;
    busAddr = a; busWdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    access(1'b0, 2'd0, 1'b0, 8'h20, 32'h0);
    check("R1", "priv reset", rdData, 32'h3);
    access(1'b0, 2'd0, 1'b0, 8'h2C, 32'h0);
    check("R1", "acl reset", rdData, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      access(v[77], v[76:75], v[74], v[73:66], v[65:34]);
      check(tagOf(i), $sformatf("vec%0d err", i), {31'b0, busErr}, {31'b0, v[33]});
      check("R3", $sformatf("vec%0d eff", i), {31'b0, effSuper}, {31'b0, v[0]});
      if (!v[77]) check(tagOf(i), $sformatf("vec%0d rd", i), rdData, v[32:1]);
    end

    // R11: write strobe without select is ignored and never errors
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b1; busMaster = 2'd3; busAddr = 8'h24; busWdata = 32'hDEAD_BEEF;
    #1;
    check("R11", "err without select", {31'b0, busErr}, 32'h0);
    access(1'b0, 2'd0, 1'b0, 8'h24, 32'h0);
    check("R11", "acl after unselected write", rdData, 32'hA5A5_0001);

    // R3: master 0 passes user attribute through as user
    access(1'b0, 2'd0, 1'b0, 8'h20, 32'h0);
    check("R3", "m0 user passthrough", {31'b0, effSuper}, 32'h0);

    // R5: master 3 untrusted on privilege register itself
    access(1'b1, 2'd3, 1'b1, 8'h20, 32'hF);
    check("R5", "m3 priv write err", {31'b0, busErr}, 32'h1);
    access(1'b0, 2'd3, 1'b1, 8'h20, 32'h0);
    check("R5", "priv unchanged", rdData, 32'h1);

    // R1 again after a mid-run reset
    idle();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    access(1'b0, 2'd1, 1'b1, 8'h20, 32'h0);
    check("R1", "priv after re-reset", rdData, 32'h3);
    check("R3", "m1 super after reset", {31'b0, effSuper}, 32'h1);
    access(1'b0, 2'd1, 1'b1, 8'h24, 32'h0);
    check("R1", "acl after re-reset", rdData, 32'h0);

    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule